// File: doc/BRIEF.md
# Instruction Pair Fusion Detector

This block sits right after the instruction decoder. It looks at a window of two decoded instructions and decides whether the pair forms one of a fixed set of idioms. A single ALU can execute such an idiom as one micro-operation in one cycle. When the pair matches, the block emits one merged micro-operation and tells the window to advance by two. When it does not match, the first instruction passes through unchanged and the window advances by one. The block only classifies and merges operand fields. Executing the operations is left to the ALUs, and each of the two ALUs can take a fused micro-operation.

Six idioms are recognised:
- a long register copy followed by an operation on the copy's target, which becomes a three-operand operation;
- a byte or word load followed by sign extension of the same register;
- a zero quick-load followed by a byte or word load into the same register, which becomes a zero-extending load;
- a quick-load followed by a register OR or AND into the same register;
- a decrement by one followed by a short branch-if-not-equal;
- two long memory-to-memory moves that both post-increment, or both pre-decrement, the same pair of address registers, which become one 64-bit move.

Both sides use valid/ready.
- The window is taken on a clock edge where `in_valid` and `in_ready` are both high. At that edge `in_adv2` tells upstream how many instructions were consumed.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- The result appears in the output register one cycle after it is taken. It stays stable while `out_valid` is high and `out_ready` is low.

Top module: `pair_fuser`

## Requirements

Encodings:

| Field | Codes |
|---|---|
| Operation classes | 0 none, 1 register copy, 2 add, 3 subtract, 4 AND, 5 OR, 6 shift, 7 load, 8 sign-extend, 9 quick-load, 10 quick-decrement, 11 short branch-if-not-equal, 12 memory-to-memory move |
| Sizes | 0 byte, 1 word, 2 long |
| Addressing modes | 0 register direct, 1 post-increment, 2 pre-decrement, 3 indirect |
| Output kinds | 0 single, 1 three-operand, 2 sign-extending load, 3 zero-extending load, 4 immediate logic, 5 loop branch, 6 paired 64-bit move |

For a load, `src` is the address register. For a sign-extend, the size field gives the width being extended.

- R1: Slot 0 is a long copy (1) from `src` to Dm. Slot 1 is a long add, subtract, AND, OR or shift (2 to 6) whose `dst` is Dm and that uses an immediate or a register. Together they give kind 1: op = slot 1 op, size long, src_a = copy source, dst = Dm, mode 0. With an immediate, src_b = 0, has_imm = 1 and imm = slot 1 immediate. Otherwise src_b = slot 1 `src`, has_imm = 0 and imm = 0.
- R2: A copy pair or a quick-load/logic pair does not fuse in three cases: slot 1 reads the shared register as its register source, slot 1's `dst` differs from slot 0's `dst`, or slot 1 is not long.
- R3: A byte or word load (7) into Dn, followed by a sign-extend (8) of Dn of the same size, gives kind 2: op 7, size and mode and src_a from the load, dst = Dn.
- R4: A quick-load (9) of immediate 0 into Dn, followed by a byte or word load into Dn, gives kind 3: op 7, size, mode and src_a from the load, dst = Dn. A nonzero quick value or a long load does not fuse.
- R5: A quick-load into Dn, followed by a long register (non-immediate) AND or OR into Dn from another register, gives kind 4: op = slot 1 op, size long, src_a = slot 1 `src`, has_imm = 1, imm = quick value, dst = Dn.
- R6: A quick-decrement (10) with immediate 1, followed by a short branch-if-not-equal (11), gives kind 5: op 11, size = decrement size, src_a = dst = Dn, has_imm = 1, imm = branch displacement. Other decrement values do not fuse.
- R7: Two long memory-to-memory moves (12) with equal `src`, equal `dst` and the same mode, which is 1 or 2, give kind 6: op 12, size long, src_a = `src`, dst = `dst`, mode kept. Mixed modes, mode 0 or 3, or a different register do not fuse.
- R8: `in_adv2` is high exactly when `in_valid` is high and the window fuses. No fusion occurs when slot 1 is invalid. A fused output has `out_fused` = 1.
- R9: Without fusion, the output is kind 0 and carries slot 0's op, size, src, dst, mode, has_imm and imm, with src_b = 0 and out_fused = 0. At most one idiom matches a window.
- R10: `in_ready` = not `out_valid` or `out_ready`. A taken window shows at the output one cycle later. A stalled output holds all its fields. After reset `out_valid` is 0.
- R11: Every output field that the kind does not define reads zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slot 0 holds an instruction |
| in_ready | output | 1 | Window can be taken this cycle |
| in_adv2 | output | 1 | Window fuses; consume two |
| s0_op | input | 4 | Slot 0 operation class |
| s0_size | input | 2 | Slot 0 size |
| s0_src | input | 5 | Slot 0 source register |
| s0_dst | input | 5 | Slot 0 destination register |
| s0_mode | input | 2 | Slot 0 addressing mode |
| s0_has_imm | input | 1 | Slot 0 carries an immediate |
| s0_imm | input | 16 | Slot 0 immediate |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_op | input | 4 | Slot 1 operation class |
| s1_size | input | 2 | Slot 1 size |
| s1_src | input | 5 | Slot 1 source register |
| s1_dst | input | 5 | Slot 1 destination register |
| s1_mode | input | 2 | Slot 1 addressing mode |
| s1_has_imm | input | 1 | Slot 1 carries an immediate |
| s1_imm | input | 16 | Slot 1 immediate |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Consumer takes the micro-operation |
| out_fused | output | 1 | Micro-operation merges two instructions |
| out_kind | output | 3 | Output kind |
| out_op | output | 4 | Operation class |
| out_size | output | 2 | Size |
| out_src_a | output | 5 | First source |
| out_src_b | output | 5 | Second register source |
| out_dst | output | 5 | Destination |
| out_mode | output | 2 | Addressing mode |
| out_has_imm | output | 1 | Immediate present |
| out_imm | output | 16 | Immediate or displacement |

## Verification

Some properties are checked on every cycle:
- a lone slot never fuses;
- no two idioms claim the same window;
- a stalled micro-operation keeps its fields;
- a taken window, fused or not, reaches the output on the next edge.

Other properties only the bench's scenarios can show:
- that each idiom merges the right operand fields;
- that the near-miss pairs stay unfused (shared source read, wrong size, nonzero quick value, mixed modes);
- that unused fields read zero.

These are compared against a behavioural model under random back-pressure.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;
  localparam int N_IDIOM = 6;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_COPY   = 4'd1,
    OP_ADD    = 4'd2,
    OP_SUB    = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_SHIFT  = 4'd6,
    OP_LOAD   = 4'd7,
    OP_EXT    = 4'd8,
    OP_QUICK  = 4'd9,
    OP_DECQ   = 4'd10,
    OP_BNE    = 4'd11,
    OP_MEMMOV = 4'd12
  } op_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_L = 2'd2;

  localparam logic [1:0] AM_REG  = 2'd0;
  localparam logic [1:0] AM_POST = 2'd1;
  localparam logic [1:0] AM_PRE  = 2'd2;

  typedef enum logic [2:0] {
    K_SINGLE   = 3'd0,
    K_TRIADIC  = 3'd1,
    K_SEXT     = 3'd2,
    K_ZEXT     = 3'd3,
    K_IMMLOGIC = 3'd4,
    K_LOOP     = 3'd5,
    K_PAIR64   = 3'd6
  } kind_e;

  typedef struct packed {
    op_e              op;
    logic [1:0]       size;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [1:0]       mode;
    logic             has_imm;
    logic [IMM_W-1:0] imm;
  } instr_t;

  typedef struct packed {
    kind_e            kind;
    op_e              op;
    logic [1:0]       size;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic [1:0]       mode;
    logic             has_imm;
    logic [IMM_W-1:0] imm;
  } uop_t;
endpackage

// File: rtl/fz_idiom_match.sv
module fz_idiom_match
  import fz_pkg::*;
(
  input  instr_t             a,
  input  instr_t             b,
  input  logic               b_valid,
  output logic [N_IDIOM-1:0] hits,
  output uop_t               cand [N_IDIOM]
);
  logic same_dst, b_reads_shared, a_narrow, b_narrow, b_alu, b_logic;
  logic m_triadic, m_sext, m_zext, m_immlog, m_loop, m_pair;

  always_comb begin
    same_dst       = (b.dst == a.dst);
    b_reads_shared = !b.has_imm && (b.src == a.dst);
    a_narrow       = (a.size == SZ_B) || (a.size == SZ_W);
    b_narrow       = (b.size == SZ_B) || (b.size == SZ_W);
    b_alu          = (b.op == OP_ADD) || (b.op == OP_SUB) || (b.op == OP_AND) ||
                     (b.op == OP_OR)  || (b.op == OP_SHIFT);
    b_logic        = (b.op == OP_AND) || (b.op == OP_OR);

    m_triadic = (a.op == OP_COPY) && (a.size == SZ_L) && b_alu &&
                (b.size == SZ_L) && same_dst && !b_reads_shared;
    m_sext    = (a.op == OP_LOAD) && a_narrow && (b.op == OP_EXT) &&
                (b.size == a.size) && same_dst;
    m_zext    = (a.op == OP_QUICK) && a.has_imm && (a.imm == '0) &&
                (b.op == OP_LOAD) && b_narrow && same_dst;
    m_immlog  = (a.op == OP_QUICK) && a.has_imm && b_logic && !b.has_imm &&
                (b.size == SZ_L) && same_dst && (b.src != a.dst);
    m_loop    = (a.op == OP_DECQ) && a.has_imm && (a.imm == IMM_W'(1)) &&
                (b.op == OP_BNE);
    m_pair    = (a.op == OP_MEMMOV) && (b.op == OP_MEMMOV) &&
                (a.size == SZ_L) && (b.size == SZ_L) && (a.mode == b.mode) &&
                ((a.mode == AM_POST) || (a.mode == AM_PRE)) &&
                (b.src == a.src) && (b.dst == a.dst);

    hits = {m_pair, m_loop, m_immlog, m_zext, m_sext, m_triadic} &
           {N_IDIOM{b_valid}};

    for (int i = 0; i < N_IDIOM; i++) cand[i] = '0;

    // three-operand: copy source is first operand, slot 1 supplies the second
    cand[0].kind    = K_TRIADIC;
    cand[0].op      = b.op;
    cand[0].size    = SZ_L;
    cand[0].src_a   = a.src;
    cand[0].src_b   = b.has_imm ? '0 : b.src;
    cand[0].dst     = a.dst;
    cand[0].has_imm = b.has_imm;
    cand[0].imm     = b.has_imm ? b.imm : '0;

    // sign-extending load keeps the load's addressing
    cand[1].kind  = K_SEXT;
    cand[1].op    = OP_LOAD;
    cand[1].size  = a.size;
    cand[1].src_a = a.src;
    cand[1].dst   = a.dst;
    cand[1].mode  = a.mode;

    // zero-extending load takes the addressing of the second instruction
    cand[2].kind  = K_ZEXT;
    cand[2].op    = OP_LOAD;
    cand[2].size  = b.size;
    cand[2].src_a = b.src;
    cand[2].dst   = a.dst;
    cand[2].mode  = b.mode;

    // quick value becomes the immediate operand of the logic operation
    cand[3].kind    = K_IMMLOGIC;
    cand[3].op      = b.op;
    cand[3].size    = SZ_L;
    cand[3].src_a   = b.src;
    cand[3].dst     = a.dst;
    cand[3].has_imm = 1'b1;
    cand[3].imm     = a.imm;

    // loop branch: counter register plus branch displacement
    cand[4].kind    = K_LOOP;
    cand[4].op      = OP_BNE;
    cand[4].size    = a.size;
    cand[4].src_a   = a.dst;
    cand[4].dst     = a.dst;
    cand[4].has_imm = 1'b1;
    cand[4].imm     = b.imm;

    // paired long moves become one 64-bit move
    cand[5].kind  = K_PAIR64;
    cand[5].op    = OP_MEMMOV;
    cand[5].size  = SZ_L;
    cand[5].src_a = a.src;
    cand[5].dst   = a.dst;
    cand[5].mode  = a.mode;
  end
endmodule

// File: rtl/fz_select.sv
module fz_select
  import fz_pkg::*;
(
  input  instr_t             a,
  input  logic [N_IDIOM-1:0] hits,
  input  uop_t               cand [N_IDIOM],
  output logic               fuse,
  output uop_t               sel
);
  uop_t masked [N_IDIOM];
  uop_t single;

  for (genvar g = 0; g < N_IDIOM; g++) begin : g_mask
    assign masked[g] = hits[g] ? cand[g] : '0;
  end

  always_comb begin
    single         = '0;
    single.kind    = K_SINGLE;
    single.op      = a.op;
    single.size    = a.size;
    single.src_a   = a.src;
    single.dst     = a.dst;
    single.mode    = a.mode;
    single.has_imm = a.has_imm;
    single.imm     = a.imm;

    fuse = |hits;
    sel  = fuse ? '0 : single;
    for (int i = 0; i < N_IDIOM; i++) sel = sel | masked[i];
  end
endmodule

// File: rtl/fz_out_stage.sv
module fz_out_stage
  import fz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  uop_t in_uop,
  output logic out_valid,
  input  logic out_ready,
  output uop_t out_uop
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_uop   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_uop <= in_uop;
    end
  end
endmodule

// File: rtl/pair_fuser.sv
module pair_fuser
  import fz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             in_adv2,
  input  logic [3:0]       s0_op,
  input  logic [1:0]       s0_size,
  input  logic [REG_W-1:0] s0_src,
  input  logic [REG_W-1:0] s0_dst,
  input  logic [1:0]       s0_mode,
  input  logic             s0_has_imm,
  input  logic [IMM_W-1:0] s0_imm,
  input  logic             s1_valid,
  input  logic [3:0]       s1_op,
  input  logic [1:0]       s1_size,
  input  logic [REG_W-1:0] s1_src,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [1:0]       s1_mode,
  input  logic             s1_has_imm,
  input  logic [IMM_W-1:0] s1_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_fused,
  output logic [2:0]       out_kind,
  output logic [3:0]       out_op,
  output logic [1:0]       out_size,
  output logic [REG_W-1:0] out_src_a,
  output logic [REG_W-1:0] out_src_b,
  output logic [REG_W-1:0] out_dst,
  output logic [1:0]       out_mode,
  output logic             out_has_imm,
  output logic [IMM_W-1:0] out_imm
);
  instr_t             slot_a, slot_b;
  logic [N_IDIOM-1:0] hits;
  uop_t               cand [N_IDIOM];
  uop_t               merged, held;
  logic               fuse;

  assign slot_a = '{op: op_e'(s0_op), size: s0_size, src: s0_src, dst: s0_dst,
                    mode: s0_mode, has_imm: s0_has_imm, imm: s0_imm};
  assign slot_b = '{op: op_e'(s1_op), size: s1_size, src: s1_src, dst: s1_dst,
                    mode: s1_mode, has_imm: s1_has_imm, imm: s1_imm};

  fz_idiom_match u_match (
    .a(slot_a), .b(slot_b), .b_valid(s1_valid), .hits(hits), .cand(cand)
  );

  fz_select u_select (
    .a(slot_a), .hits(hits), .cand(cand), .fuse(fuse), .sel(merged)
  );

  fz_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uop(merged), .out_valid(out_valid), .out_ready(out_ready),
    .out_uop(held)
  );

  assign in_adv2     = in_valid && fuse;
  assign out_kind    = held.kind;
  assign out_fused   = (held.kind != K_SINGLE);
  assign out_op      = held.op;
  assign out_size    = held.size;
  assign out_src_a   = held.src_a;
  assign out_src_b   = held.src_b;
  assign out_dst     = held.dst;
  assign out_mode    = held.mode;
  assign out_has_imm = held.has_imm;
  assign out_imm     = held.imm;
endmodule

// File: rtl/fz_checker.sv
module fz_checker
  import fz_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_adv2,
  input logic               s1_valid,
  input logic [N_IDIOM-1:0] hits,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2:0]         out_kind,
  input logic [REG_W-1:0]   out_dst,
  input logic [REG_W-1:0]   out_src_a,
  input logic [IMM_W-1:0]   out_imm
);
  // R8: a lone slot never fuses
  assert_lone_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !s1_valid |-> !in_adv2);

  // R8: a taken fused window yields a fused kind next cycle
  assert_fused_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_adv2 |=> out_valid && (out_kind != 3'd0));

  // R9: at most one idiom claims a window
  assert_one_idiom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));

  // R10: empty output register always accepts
  assert_ready_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10: a taken window appears one cycle later
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: stalled output holds its fields
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) &&
    $stable(out_dst) && $stable(out_src_a) && $stable(out_imm));
endmodule

bind pair_fuser fz_checker u_fz_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_adv2(in_adv2), .s1_valid(s1_valid), .hits(hits), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_dst(out_dst),
  .out_src_a(out_src_a), .out_imm(out_imm)
);

// File: tb/pair_fuser_bench.sv
module pair_fuser_bench;
  import fz_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, s1_valid = 0, out_ready = 0;
  instr_t a = '0, b = '0;
  logic in_ready, in_adv2, out_valid, out_fused, out_has_imm;
  logic [2:0] out_kind;
  logic [3:0] out_op;
  logic [1:0] out_size, out_mode;
  logic [REG_W-1:0] out_src_a, out_src_b, out_dst;
  logic [IMM_W-1:0] out_imm;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_fuser u_pair_fuser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_adv2(in_adv2),
    .s0_op(a.op), .s0_size(a.size), .s0_src(a.src), .s0_dst(a.dst),
    .s0_mode(a.mode), .s0_has_imm(a.has_imm), .s0_imm(a.imm),
    .s1_valid(s1_valid),
    .s1_op(b.op), .s1_size(b.size), .s1_src(b.src), .s1_dst(b.dst),
    .s1_mode(b.mode), .s1_has_imm(b.has_imm), .s1_imm(b.imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused),
    .out_kind(out_kind), .out_op(out_op), .out_size(out_size),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_mode(out_mode), .out_has_imm(out_has_imm), .out_imm(out_imm)
  );

  // model state: the micro-operation expected in the output register
  bit    m_valid = 0;
  uop_t  m_uop = '0;
  string m_tag = "R10";

  function automatic instr_t mk(op_e op, logic [1:0] sz, int s, int d,
                                logic [1:0] md, bit hi, int im);
    instr_t r;
    r.op = op; r.size = sz; r.src = REG_W'(s); r.dst = REG_W'(d);
    r.mode = md; r.has_imm = hi; r.imm = IMM_W'(im);
    return r;
  endfunction

  // behavioural reference of the requirements
  function automatic uop_t expect_uop(instr_t x, instr_t y, bit yv);
    uop_t u = '0;
    bool_narrow: begin end
    if (yv && x.op == OP_COPY && x.size == 2 && y.size == 2 && y.dst == x.dst &&
        y.op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SHIFT} &&
        (y.has_imm || y.src != x.dst)) begin
      u.kind = K_TRIADIC; u.op = y.op; u.size = 2; u.src_a = x.src;
      u.dst = x.dst; u.has_imm = y.has_imm;
      if (y.has_imm) u.imm = y.imm; else u.src_b = y.src;
    end else if (yv && x.op == OP_LOAD && x.size < 2 && y.op == OP_EXT &&
                 y.size == x.size && y.dst == x.dst) begin
      u.kind = K_SEXT; u.op = OP_LOAD; u.size = x.size; u.src_a = x.src;
      u.dst = x.dst; u.mode = x.mode;
    end else if (yv && x.op == OP_QUICK && x.has_imm && x.imm == 0 &&
                 y.op == OP_LOAD && y.size < 2 && y.dst == x.dst) begin
      u.kind = K_ZEXT; u.op = OP_LOAD; u.size = y.size; u.src_a = y.src;
      u.dst = x.dst; u.mode = y.mode;
    end else if (yv && x.op == OP_QUICK && x.has_imm &&
                 (y.op == OP_AND || y.op == OP_OR) && !y.has_imm &&
                 y.size == 2 && y.dst == x.dst && y.src != x.dst) begin
      u.kind = K_IMMLOGIC; u.op = y.op; u.size = 2; u.src_a = y.src;
      u.dst = x.dst; u.has_imm = 1; u.imm = x.imm;
    end else if (yv && x.op == OP_DECQ && x.has_imm && x.imm == 1 &&
                 y.op == OP_BNE) begin
      u.kind = K_LOOP; u.op = OP_BNE; u.size = x.size; u.src_a = x.dst;
      u.dst = x.dst; u.has_imm = 1; u.imm = y.imm;
    end else if (yv && x.op == OP_MEMMOV && y.op == OP_MEMMOV && x.size == 2 &&
                 y.size == 2 && x.mode == y.mode && (x.mode == 1 || x.mode == 2) &&
                 x.src == y.src && x.dst == y.dst) begin
      u.kind = K_PAIR64; u.op = OP_MEMMOV; u.size = 2; u.src_a = x.src;
      u.dst = x.dst; u.mode = x.mode;
    end else begin
      u.kind = K_SINGLE; u.op = x.op; u.size = x.size; u.src_a = x.src;
      u.dst = x.dst; u.mode = x.mode; u.has_imm = x.has_imm; u.imm = x.imm;
    end
    return u;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle: inputs set after falling edge, everything compared there
  task automatic step(instr_t x, instr_t y, bit iv, bit yv, bit rdy, string tag);
    uop_t nu, got;
    bit   exp_ready;
    @(negedge clk);
    a = x; b = y; in_valid = iv; s1_valid = yv; out_ready = rdy;
    #1;
    got = '{kind: kind_e'(out_kind), op: op_e'(out_op), size: out_size,
            src_a: out_src_a, src_b: out_src_b, dst: out_dst, mode: out_mode,
            has_imm: out_has_imm, imm: out_imm};
    check(out_valid == m_valid, "R10", "out_valid", out_valid, m_valid);
    if (m_valid) begin
      check(got == m_uop, m_tag, "uop", got, m_uop);
      check(out_fused == (m_uop.kind != K_SINGLE), "R8", "out_fused",
            out_fused, m_uop.kind != K_SINGLE);
    end
    exp_ready = !m_valid || rdy;
    check(in_ready == exp_ready, "R10", "in_ready", in_ready, exp_ready);
    nu = expect_uop(x, y, yv);
    check(in_adv2 == (iv && nu.kind != K_SINGLE), "R8", "in_adv2",
          in_adv2, iv && nu.kind != K_SINGLE);
    if (iv && exp_ready) begin
      m_valid = 1; m_uop = nu; m_tag = tag;
    end else if (rdy) begin
      m_valid = 0;
    end
  endtask

  task automatic pair(instr_t x, instr_t y, string tag);
    step(x, y, 1, 1, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    instr_t n0 = '0;
    #(CLK_PERIOD * 2 + 1);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset actual=%0b%0b expected=01", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1;

    // R1 copy-then-operate, register and immediate forms
    pair(mk(OP_COPY, 2, 1, 2, 0, 0, 0), mk(OP_ADD, 2, 3, 2, 0, 0, 0), "R1");
    pair(mk(OP_COPY, 2, 4, 5, 0, 0, 0), mk(OP_SHIFT, 2, 0, 5, 0, 1, 2), "R1");
    pair(mk(OP_COPY, 2, 4, 5, 0, 0, 0), mk(OP_SUB, 2, 7, 5, 0, 0, 0), "R1");
    // R2 near misses
    pair(mk(OP_COPY, 2, 1, 2, 0, 0, 0), mk(OP_ADD, 2, 2, 2, 0, 0, 0), "R2");
    pair(mk(OP_COPY, 2, 1, 2, 0, 0, 0), mk(OP_AND, 2, 3, 6, 0, 0, 0), "R2");
    pair(mk(OP_COPY, 2, 1, 2, 0, 0, 0), mk(OP_OR, 1, 3, 2, 0, 0, 0), "R2");
    pair(mk(OP_QUICK, 2, 0, 3, 0, 1, 5), mk(OP_OR, 2, 3, 3, 0, 0, 0), "R2");
    // R3 sign-extending loads
    pair(mk(OP_LOAD, 0, 8, 3, 1, 0, 0), mk(OP_EXT, 0, 0, 3, 0, 0, 0), "R3");
    pair(mk(OP_LOAD, 1, 9, 4, 3, 0, 0), mk(OP_EXT, 1, 0, 4, 0, 0, 0), "R3");
    pair(mk(OP_LOAD, 0, 8, 3, 1, 0, 0), mk(OP_EXT, 1, 0, 3, 0, 0, 0), "R3");
    // R4 zero-extending loads
    pair(mk(OP_QUICK, 2, 0, 6, 0, 1, 0), mk(OP_LOAD, 0, 10, 6, 1, 0, 0), "R4");
    pair(mk(OP_QUICK, 2, 0, 6, 0, 1, 0), mk(OP_LOAD, 1, 11, 6, 3, 0, 0), "R4");
    pair(mk(OP_QUICK, 2, 0, 6, 0, 1, 3), mk(OP_LOAD, 0, 10, 6, 1, 0, 0), "R4");
    pair(mk(OP_QUICK, 2, 0, 6, 0, 1, 0), mk(OP_LOAD, 2, 10, 6, 1, 0, 0), "R4");
    // R5 quick then logic
    pair(mk(OP_QUICK, 2, 0, 7, 0, 1, 'h7f), mk(OP_AND, 2, 1, 7, 0, 0, 0), "R5");
    pair(mk(OP_QUICK, 2, 0, 7, 0, 1, 'hf0), mk(OP_OR, 2, 2, 7, 0, 0, 0), "R5");
    // R6 loop branch
    pair(mk(OP_DECQ, 2, 0, 1, 0, 1, 1), mk(OP_BNE, 0, 0, 0, 0, 1, 'hfffc), "R6");
    pair(mk(OP_DECQ, 1, 0, 1, 0, 1, 2), mk(OP_BNE, 0, 0, 0, 0, 1, 'hfffc), "R6");
    // R7 paired moves
    pair(mk(OP_MEMMOV, 2, 2, 3, 1, 0, 0), mk(OP_MEMMOV, 2, 2, 3, 1, 0, 0), "R7");
    pair(mk(OP_MEMMOV, 2, 2, 3, 2, 0, 0), mk(OP_MEMMOV, 2, 2, 3, 2, 0, 0), "R7");
    pair(mk(OP_MEMMOV, 2, 2, 3, 1, 0, 0), mk(OP_MEMMOV, 2, 2, 3, 2, 0, 0), "R7");
    pair(mk(OP_MEMMOV, 2, 2, 3, 3, 0, 0), mk(OP_MEMMOV, 2, 2, 3, 3, 0, 0), "R7");
    pair(mk(OP_MEMMOV, 2, 2, 3, 1, 0, 0), mk(OP_MEMMOV, 2, 4, 3, 1, 0, 0), "R7");
    // R8 lone slot, R9 pass-through, R11 zeros
    step(mk(OP_COPY, 2, 1, 2, 0, 0, 0), mk(OP_ADD, 2, 3, 2, 0, 0, 0), 1, 0, 1, "R8");
    step(mk(OP_DECQ, 2, 0, 1, 0, 1, 1), mk(OP_BNE, 0, 0, 0, 0, 1, 8), 0, 1, 1, "R8");
    pair(mk(OP_SUB, 1, 3, 4, 2, 1, 'h1234), n0, "R9");
    pair(mk(OP_LOAD, 0, 9, 3, 1, 1, 'h55), mk(OP_EXT, 0, 0, 3, 0, 1, 9), "R11");
    // R10 stall then drain
    step(mk(OP_ADD, 2, 1, 2, 0, 0, 0), n0, 1, 0, 0, "R10");
    step(mk(OP_OR, 2, 3, 4, 0, 0, 0), n0, 1, 0, 0, "R10");
    step(mk(OP_OR, 2, 3, 4, 0, 0, 0), n0, 1, 0, 0, "R10");
    step(mk(OP_OR, 2, 3, 4, 0, 0, 0), n0, 1, 0, 1, "R10");
    step(n0, n0, 0, 0, 1, "R10");
    step(n0, n0, 0, 0, 1, "R10");

    // random stream with back-pressure
    for (int i = 0; i < 3000; i++) begin
      instr_t x, y;
      x = mk(op_e'($urandom_range(1, 12)), 2'($urandom_range(0, 2)),
             $urandom_range(0, 3), $urandom_range(0, 3), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), $urandom_range(0, 2));
      y = mk(op_e'($urandom_range(1, 12)), 2'($urandom_range(0, 2)),
             $urandom_range(0, 3), $urandom_range(0, 3), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), $urandom_range(0, 2));
      if (i % 3 == 0) begin y.dst = x.dst; y.size = x.size; y.mode = x.mode; end
      step(x, y, $urandom_range(0, 4) != 0, $urandom_range(0, 9) != 0,
           $urandom_range(0, 9) < 7, "R9");
    end
    step('0, '0, 0, 0, 1, "R10");
    step('0, '0, 0, 0, 1, "R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule